// File: doc/BRIEF.md
# Wobble Data Word Read Port

This block sits between the wobble bit detector and the on-chip microprocessor. Each time the detector finishes a 24-bit data word, the block stores it in a holding register and raises a ready flag. The processor polls a status location on a small address/read-strobe bus to find new words. It then collects the word through two separate locations: one returns the upper 16 bits and the other returns the lower 8 bits.

A transfer counts as finished only when both word locations have been read since the word was stored. The two reads may come in either order. If the detector delivers another word before the current transfer has finished, the new word replaces the stored one and a warning flag is set. Reading the status location clears the warning flag. Read data is registered and appears one clock after the read strobe.

Top module: `wdat_rd_port`

## Requirements
- R1: After synchronous reset, `rd_data` is zero and the status word reads zero (ready = 0, warning = 0).
- R2: A `word_vld` pulse stores `word_in`, and the ready flag (status bit 0) reads 1 from the next cycle.
- R3: A read of address 1 returns `{word[23:8]}` on `rd_data` in the cycle after the strobe.
- R4: A read of address 2 returns `{8'h00, word[7:0]}` in the cycle after the strobe.
- R5: The ready flag clears only once both address 1 and address 2 have been read since the word was stored, in either order. A single read leaves the flag set.
- R6: A word that arrives while a transfer is unfinished overwrites the stored word and sets the warning flag (status bit 1). The ready flag stays set, and read progress restarts, so both reads are needed again.
- R7: A read of address 0 returns `{14'b0, warning, ready}` and clears the warning flag. If an overrunning word arrives in the same cycle, the warning flag stays set.
- R8: Reads of any address other than 0, 1 and 2 return zero and change neither flag.
- R9: A word that arrives while the ready flag is clear does not set the warning flag.
- R10: A word that arrives in the same cycle as the read that finishes the previous transfer does not set the warning flag, and the ready flag stays set for the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_vld | input | 1 | One-cycle pulse: a new word is on `word_in` |
| word_in | input | 24 | Decoded wobble data word |
| rd_en | input | 1 | Read strobe from the processor |
| rd_addr | input | 4 | Read address (0 status, 1 upper word, 2 lower word) |
| rd_data | output | 16 | Registered read data, valid the cycle after `rd_en` |

## Verification
The bench runs the following patterns:
- Reading the upper part before the lower part, and the reverse order. This separates a design that tracks each half on its own from one that expects a fixed order.
- Single reads followed by a status poll. These show that a partial transfer does not clear the ready flag.
- Words that overrun an unread word, and a partly read word. These show that overwriting restarts read progress.
- Same-cycle collisions of a new word with a status read, and of a new word with the finishing read. These settle whether a warning is set or cleared at those boundaries.
- Reads of unmapped addresses between a store and a status poll. These show that such reads have no effect on either flag.

// File: rtl/wdat_pkg.sv
package wdat_pkg;

    // Which register a read strobe selects in the current cycle
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_HI   = 2'd2,
        SEL_LO   = 2'd3
    } rd_sel_e;

    // Flags visible in the status register
    typedef struct packed {
        logic warn;
        logic ready;
    } wdat_stat_t;

    // Progress of the host through the current word
    typedef struct packed {
        logic hi_seen;
        logic lo_seen;
    } wdat_prog_t;

    // Transfer is finished when both halves are covered by history or this cycle
    function automatic logic xfer_done(wdat_prog_t p, rd_sel_e s);
        return (p.hi_seen || s == SEL_HI) && (p.lo_seen || s == SEL_LO);
    endfunction

endpackage

// File: rtl/wdat_rd_decode.sv
module wdat_rd_decode
    import wdat_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int ADDR_STAT = 0,
    parameter int ADDR_HI   = 1,
    parameter int ADDR_LO   = 2
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output rd_sel_e           sel
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);
    localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(ADDR_HI);
    localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(ADDR_LO);

    always_comb begin
        sel = SEL_NONE;
        if (rd_en) begin
            if (rd_addr == A_STAT)    sel = SEL_STAT;
            else if (rd_addr == A_HI) sel = SEL_HI;
            else if (rd_addr == A_LO) sel = SEL_LO;
        end
    end
endmodule

// File: rtl/wdat_hold.sv
module wdat_hold
    import wdat_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word_in,
    input  rd_sel_e           sel,
    output logic [WORD_W-1:0] hold_q,
    output wdat_stat_t        stat_q
);
    wdat_prog_t prog_q;
    logic       done_now;
    logic       overrun;

    assign done_now = stat_q.ready && xfer_done(prog_q, sel);
    assign overrun  = word_vld && stat_q.ready && !done_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            stat_q <= '0;
            prog_q <= '0;
        end else begin
            // warning: a fresh overrun wins over a clearing status read
            if (overrun)              stat_q.warn <= 1'b1;
            else if (sel == SEL_STAT) stat_q.warn <= 1'b0;

            if (word_vld) begin
                hold_q       <= word_in;
                stat_q.ready <= 1'b1;
                prog_q       <= '0;
            end else if (stat_q.ready) begin
                if (done_now) begin
                    stat_q.ready <= 1'b0;
                    prog_q       <= '0;
                end else begin
                    if (sel == SEL_HI) prog_q.hi_seen <= 1'b1;
                    if (sel == SEL_LO) prog_q.lo_seen <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/wdat_rd_mux.sv
module wdat_rd_mux
    import wdat_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int LO_W   = 8,
    parameter int RD_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  rd_sel_e           sel,
    input  logic [WORD_W-1:0] hold_q,
    input  wdat_stat_t        stat_q,
    output logic [RD_W-1:0]   rd_data
);
    localparam int HI_W = WORD_W - LO_W;

    logic [RD_W-1:0] nxt;

    always_comb begin
        case (sel)
            SEL_STAT: nxt = RD_W'(stat_q);
            SEL_HI:   nxt = RD_W'(hold_q[WORD_W-1:LO_W]);
            SEL_LO:   nxt = RD_W'(hold_q[LO_W-1:0]);
            default:  nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rd_data <= '0;
        else     rd_data <= nxt;
    end

    // The upper part must fit in one read word
    if (HI_W > RD_W) begin : g_bad_width
        initial $error("upper word part wider than read bus");
    end
endmodule

// File: rtl/wdat_rd_port.sv
module wdat_rd_port
    import wdat_pkg::*;
#(
    parameter int WORD_W    = 24,
    parameter int LO_W      = 8,
    parameter int RD_W      = 16,
    parameter int ADDR_W    = 4,
    parameter int ADDR_STAT = 0,
    parameter int ADDR_HI   = 1,
    parameter int ADDR_LO   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word_in,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [RD_W-1:0]   rd_data
);
    rd_sel_e           sel;
    logic [WORD_W-1:0] hold_q;
    wdat_stat_t        stat_q;
    logic              ready_q;
    logic              warn_q;

    assign ready_q = stat_q.ready;
    assign warn_q  = stat_q.warn;

    wdat_rd_decode #(
        .ADDR_W(ADDR_W), .ADDR_STAT(ADDR_STAT), .ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO)
    ) u_decode (
        .rd_en(rd_en), .rd_addr(rd_addr), .sel(sel)
    );

    wdat_hold #(.WORD_W(WORD_W)) u_hold (
        .clk(clk), .rst(rst), .word_vld(word_vld), .word_in(word_in),
        .sel(sel), .hold_q(hold_q), .stat_q(stat_q)
    );

    wdat_rd_mux #(.WORD_W(WORD_W), .LO_W(LO_W), .RD_W(RD_W)) u_mux (
        .clk(clk), .rst(rst), .sel(sel), .hold_q(hold_q),
        .stat_q(stat_q), .rd_data(rd_data)
    );
endmodule

// File: rtl/wdat_rd_port_chk.sv
module wdat_rd_port_chk #(
    parameter int WORD_W    = 24,
    parameter int LO_W      = 8,
    parameter int RD_W      = 16,
    parameter int ADDR_W    = 4,
    parameter int ADDR_STAT = 0,
    parameter int ADDR_HI   = 1,
    parameter int ADDR_LO   = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              word_vld,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [RD_W-1:0]   rd_data,
    input logic [WORD_W-1:0] hold_q,
    input logic              ready_q,
    input logic              warn_q
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);
    localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(ADDR_HI);
    localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(ADDR_LO);

    logic unmapped;
    assign unmapped = rd_addr != A_STAT && rd_addr != A_HI && rd_addr != A_LO;

    a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_data == '0 && !ready_q && !warn_q));

    a_r2_ready_set: assert property (@(posedge clk) disable iff (rst)
        word_vld |=> ready_q);

    a_r3_upper_part: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == A_HI) |=> rd_data == RD_W'($past(hold_q) >> LO_W));

    a_r5_ready_holds: assert property (@(posedge clk) disable iff (rst)
        (ready_q && !rd_en && !word_vld) |=> ready_q);

    a_r6_overrun_warns: assert property (@(posedge clk) disable iff (rst)
        (word_vld && ready_q && !rd_en) |=> warn_q);

    a_r7_status_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == A_STAT && !word_vld) |=> !warn_q);

    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && unmapped) |=> rd_data == '0);

    a_r9_warn_needs_word: assert property (@(posedge clk) disable iff (rst)
        $rose(warn_q) |-> $past(word_vld));
endmodule

bind wdat_rd_port wdat_rd_port_chk #(
    .WORD_W(WORD_W), .LO_W(LO_W), .RD_W(RD_W), .ADDR_W(ADDR_W),
    .ADDR_STAT(ADDR_STAT), .ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO)
) u_chk (
    .clk(clk), .rst(rst), .word_vld(word_vld), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .hold_q(hold_q), .ready_q(ready_q), .warn_q(warn_q)
);

// File: tb/wdat_rd_port_bench.sv
module wdat_rd_port_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        word_vld = 1'b0;
    logic [23:0] word_in = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [15:0] e;
        string       tag;
    } exp_t;
    exp_t sb_q[$];
    logic issued_q = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    wdat_rd_port u_wdat_rd_port (
        .clk(clk), .rst(rst), .word_vld(word_vld), .word_in(word_in),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus; a read pushes its expected result
    task automatic cyc(input logic v, input logic [23:0] w, input logic r,
                       input logic [3:0] a, input logic [15:0] e, input string tag);
        exp_t it;
        @(negedge clk);
        word_vld = v;
        word_in  = w;
        rd_en    = r;
        rd_addr  = a;
        if (r) begin
            it.e   = e;
            it.tag = tag;
            sb_q.push_back(it);
        end
    endtask

    task automatic rd(input logic [3:0] a, input logic [15:0] e, input string tag);
        cyc(1'b0, 24'h0, 1'b1, a, e, tag);
    endtask

    task automatic wr(input logic [23:0] w);
        cyc(1'b1, w, 1'b0, 4'h0, 16'h0, "");
    endtask

    always @(posedge clk) issued_q <= rd_en;

    // Monitor: the result of a strobe is on rd_data one cycle later
    always @(negedge clk) begin
        exp_t it;
        if (issued_q && !rst) begin
            if (sb_q.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL scoreboard: got %h expected no read", rd_data);
            end else begin
                it = sb_q.pop_front();
                check(rd_data, it.e, it.tag);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(rd_data, 16'h0000, "R1 rd_data after reset");
        rd(4'd0, 16'h0000, "R1 status after reset");

        // R2/R3/R4/R5: upper part first
        wr(24'hABCDEF);
        rd(4'd0, 16'h0001, "R2 ready after store");
        rd(4'd1, 16'hABCD, "R3 upper part");
        rd(4'd0, 16'h0001, "R5 ready after one read");
        rd(4'd2, 16'h00EF, "R4 lower part");
        rd(4'd0, 16'h0000, "R5 ready clear after both");

        // R5: lower part first
        wr(24'h123456);
        rd(4'd2, 16'h0056, "R4 lower part first");
        rd(4'd0, 16'h0001, "R5 ready after lower only");
        rd(4'd1, 16'h1234, "R3 upper part second");
        rd(4'd0, 16'h0000, "R5 reverse order clears");

        // R8: unmapped reads
        wr(24'h0F0E0D);
        rd(4'd3, 16'h0000, "R8 addr 3 reads zero");
        rd(4'd15, 16'h0000, "R8 addr 15 reads zero");
        rd(4'd0, 16'h0001, "R8 ready untouched");
        rd(4'd1, 16'h0F0E, "R8 upper intact");
        rd(4'd2, 16'h000D, "R8 lower intact");
        rd(4'd0, 16'h0000, "R8 no warning");

        // R9: word with ready clear
        wr(24'h111111);
        rd(4'd0, 16'h0001, "R9 no warning on clean arrival");

        // R6: overrun of unread word
        wr(24'hAAAA55);
        rd(4'd0, 16'h0003, "R6 warning on overrun");
        rd(4'd0, 16'h0001, "R7 status read clears warning");
        rd(4'd1, 16'hAAAA, "R6 word overwritten");
        wr(24'hBBBB66);
        rd(4'd2, 16'h0066, "R6 lower of new word");
        rd(4'd0, 16'h0003, "R6 progress restarted, warning set");
        rd(4'd0, 16'h0001, "R7 warning cleared");

        // R7: overrun in same cycle as status read
        cyc(1'b1, 24'hCCCC77, 1'b1, 4'd0, 16'h0001, "R7 status before collision");
        rd(4'd0, 16'h0003, "R7 warning kept on collision");
        rd(4'd0, 16'h0001, "R7 cleared afterwards");
        rd(4'd1, 16'hCCCC, "R3 upper of collided word");

        // R10: new word with finishing read
        cyc(1'b1, 24'hDDDD88, 1'b1, 4'd2, 16'h0077, "R10 finishing read data");
        rd(4'd0, 16'h0001, "R10 ready kept, no warning");
        rd(4'd1, 16'hDDDD, "R10 upper of new word");
        rd(4'd2, 16'h0088, "R10 lower of new word");
        rd(4'd0, 16'h0000, "R10 transfer done");

        cyc(1'b0, 24'h0, 1'b0, 4'd0, 16'h0, "");
        cyc(1'b0, 24'h0, 1'b0, 4'd0, 16'h0, "");
        @(negedge clk);
        if (sb_q.size() != 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL scoreboard: got %0d pending expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1-all: got hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule